// File: doc/BRIEF.md
# Key-protected watchdog reset timer

This block is a watchdog counter whose configuration can only be changed through a guarded write path. Software must first write an opening key to one register and then a confirming key to a second register. Only after that pair may it perform exactly one write to a guarded register: the match value, the control register or the event status. Once enabled, the counter counts clock cycles. When the count reaches the programmed match value, the block latches an event status bit. If reset generation is also enabled, it drives a fixed-length reset request pulse toward the system reset controller.

A three-state unlock machine guards the write path. Its states are `ULK_LOCKED`, `ULK_HALF` and `ULK_OPEN`. Its transitions are:
- `LOCKED -> HALF` on a correct opening key.
- `HALF -> OPEN` on a correct confirming key.
- `HALF -> LOCKED` on any other write.
- `OPEN -> LOCKED` on any write, guarded or not. A guarded write made in this transition is the one write that takes effect.
- `LOCKED -> LOCKED` on any write other than a correct opening key.

A second machine, the pulse generator, shapes the reset request. Its states are `PLS_IDLE` and `PLS_ACTIVE`. It moves `IDLE -> ACTIVE` on a match with reset generation enabled, and `ACTIVE -> IDLE` after the fixed pulse length. An external hold input keeps every register and both machines at their reset values while it is asserted.

Top module: `wdt_keyed_top`

## Requirements
- R1: The register addresses are fixed. The opening key register is at address 0 and takes 0x0000BABA. The confirming key register is at address 1 and takes 0x0000EB10. A correct opening key followed directly by a correct confirming key opens the guarded path, and the next write to a guarded register takes effect.
- R2: The unlock machine returns to locked on any of these: a wrong key value, the confirming key written before the opening key, the opening key written twice, or any other write between the two keys. A guarded write that follows such a sequence is ignored.
- R3: Only one write follows each complete key pair. That write may be to a guarded or an unguarded address. Any further guarded write is ignored until a new pair is written.
- R4: A guarded write made while locked leaves the register unchanged. The match register is at address 2 and resets to all ones. The control register is at address 3, resets to 0 and reads back in bits 1:0. The status register is at address 4. The count register is at address 5 and is read-only. The key registers read as zero.
- R5: Every register resets to its reset value through the asynchronous reset. Status, count and reset request are then all 0.
- R6: With control bit 0 set, the count starts at 0 and increases by one each cycle. After it equals the match value it restarts at 0 on the next edge.
- R7: The status bit rises on the clock edge that ends a cycle in which control bit 0 is set and the count equals the match value.
- R8: When control bit 1 is also set, the reset request goes high on the same edge as the status bit and stays high for exactly 4 cycles. A match during the pulse does not extend it.
- R9: With control bit 0 set and bit 1 clear, matches set the status bit but never raise the reset request.
- R10: When control bit 0 is cleared, the count reads 0 from the edge after the control write onward. Disabling does not clear the status bit.
- R11: A guarded write to status with bit 0 = 0 clears the status bit. With bit 0 = 1 it has no effect. If a clear and a match fall on the same edge, the status bit ends set.
- R12: While hold is high, all registers, the count, the reset request and the unlock machine are held at reset values, and writes are ignored. After hold is released, a full key pair is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Synchronous hold-in-reset request, active high |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | 3 | Read address (combinational read) |
| rd_data | output | DATA_W (32) | Read data for rd_addr |
| wdt_rst_req | output | 1 | Reset request pulse to the system reset controller |
| wdt_status | output | 1 | Latched watchdog event status |

## Verification
The match-driven setting of the status bit and the software clear of that bit can land on the same clock edge. The bench provokes this by timing its writes. It enables counting with a known match value and counts idle cycles. It then places the two key writes so that the guarded clear arrives exactly on the edge where the count equals the match value. Status must read 1 afterwards. An identical clear made away from a match must read 0, which shows that the clear itself works.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 3;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_KEY1  = 3'd0;
    localparam logic [ADDR_W-1:0] A_KEY2  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MATCH = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;

    // Unlock keys
    localparam logic [15:0] KEY_OPEN    = 16'hBABA;
    localparam logic [15:0] KEY_CONFIRM = 16'hEB10;

    // Control register bit positions
    localparam int CTRL_RUN = 0;
    localparam int CTRL_RST = 1;

    typedef enum logic [1:0] {
        ULK_LOCKED = 2'd0,
        ULK_HALF   = 2'd1,
        ULK_OPEN   = 2'd2
    } ulk_state_e;

    typedef enum logic {
        PLS_IDLE   = 1'b0,
        PLS_ACTIVE = 1'b1
    } pls_state_e;

endpackage

// File: rtl/wdt_unlock_fsm.sv
module wdt_unlock_fsm
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ulk_state_e        state_q,
    output logic              grant
);

    localparam logic [DATA_W-1:0] OPEN_VAL    = DATA_W'(KEY_OPEN);
    localparam logic [DATA_W-1:0] CONFIRM_VAL = DATA_W'(KEY_CONFIRM);

    ulk_state_e state_d;
    logic       open_hit;
    logic       confirm_hit;
    logic       guarded_addr;

    assign open_hit     = (wr_addr == A_KEY1) && (wr_data == OPEN_VAL);
    assign confirm_hit  = (wr_addr == A_KEY2) && (wr_data == CONFIRM_VAL);
    assign guarded_addr = (wr_addr == A_MATCH) || (wr_addr == A_CTRL) ||
                          (wr_addr == A_STAT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ULK_LOCKED;
        end else if (hold) begin
            state_q <= ULK_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: any write consumes or breaks the sequence
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                ULK_LOCKED: state_d = open_hit    ? ULK_HALF : ULK_LOCKED;
                ULK_HALF:   state_d = confirm_hit ? ULK_OPEN : ULK_LOCKED;
                ULK_OPEN:   state_d = ULK_LOCKED;
                default:    state_d = ULK_LOCKED;
            endcase
        end
    end

    // Output logic: the single permitted guarded write
    always_comb begin
        grant = 1'b0;
        unique case (state_q)
            ULK_LOCKED: grant = 1'b0;
            ULK_HALF:   grant = 1'b0;
            ULK_OPEN:   grant = wr_en && guarded_addr && !hold;
            default:    grant = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_prot_regs.sv
module wdt_prot_regs
    import wdt_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] MATCH_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              grant,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hit,
    output logic [DATA_W-1:0] match_q,
    output logic [1:0]        en_q,
    output logic              status_q
);

    logic wr_match;
    logic wr_ctrl;
    logic wr_clear;

    assign wr_match = grant && (wr_addr == A_MATCH);
    assign wr_ctrl  = grant && (wr_addr == A_CTRL);
    assign wr_clear = grant && (wr_addr == A_STAT) && !wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= MATCH_RST;
        end else if (hold) begin
            match_q <= MATCH_RST;
        end else if (wr_match) begin
            match_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 2'b00;
        end else if (hold) begin
            en_q <= 2'b00;
        end else if (wr_ctrl) begin
            en_q <= wr_data[1:0];
        end
    end

    // A match sets the status; it takes priority over a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (hold) begin
            status_q <= 1'b0;
        end else if (hit) begin
            status_q <= 1'b1;
        end else if (wr_clear) begin
            status_q <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_match_ctr.sv
module wdt_match_ctr
    import wdt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [1:0]        en_q,
    input  logic [DATA_W-1:0] match_q,
    output logic [DATA_W-1:0] count_q,
    output logic              hit,
    output logic              rst_req
);

    localparam int LEFT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [LEFT_W-1:0] LEFT_LOAD = LEFT_W'(PULSE_LEN - 1);

    pls_state_e        pls_q;
    pls_state_e        pls_d;
    logic [LEFT_W-1:0] left_q;
    logic [LEFT_W-1:0] left_d;
    logic              at_match;

    assign at_match = (count_q == match_q);
    assign hit      = en_q[CTRL_RUN] && at_match;

    // Watchdog counter: cleared while disabled, restarts after a match
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (hold || !en_q[CTRL_RUN]) begin
            count_q <= '0;
        end else if (at_match) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // Pulse generator state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pls_q  <= PLS_IDLE;
            left_q <= '0;
        end else if (hold) begin
            pls_q  <= PLS_IDLE;
            left_q <= '0;
        end else begin
            pls_q  <= pls_d;
            left_q <= left_d;
        end
    end

    // Pulse generator next state
    always_comb begin
        pls_d  = pls_q;
        left_d = left_q;
        unique case (pls_q)
            PLS_IDLE: begin
                if (hit && en_q[CTRL_RST]) begin
                    pls_d  = PLS_ACTIVE;
                    left_d = LEFT_LOAD;
                end
            end
            PLS_ACTIVE: begin
                if (left_q == '0) begin
                    pls_d = PLS_IDLE;
                end else begin
                    left_d = left_q - 1'b1;
                end
            end
            default: begin
                pls_d  = PLS_IDLE;
                left_d = '0;
            end
        endcase
    end

    // Pulse generator output
    always_comb begin
        unique case (pls_q)
            PLS_IDLE:   rst_req = 1'b0;
            PLS_ACTIVE: rst_req = 1'b1;
            default:    rst_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdt_rst_req,
    output logic              wdt_status
);

    ulk_state_e        ulk_state;
    logic              grant;
    logic              hit;
    logic [DATA_W-1:0] match_q;
    logic [DATA_W-1:0] count_q;
    logic [1:0]        en_q;

    wdt_unlock_fsm #(
        .DATA_W (DATA_W)
    ) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .state_q (ulk_state),
        .grant   (grant)
    );

    wdt_prot_regs #(
        .DATA_W    (DATA_W),
        .MATCH_RST ({DATA_W{1'b1}})
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .grant    (grant),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .hit      (hit),
        .match_q  (match_q),
        .en_q     (en_q),
        .status_q (wdt_status)
    );

    wdt_match_ctr #(
        .DATA_W    (DATA_W),
        .PULSE_LEN (PULSE_LEN)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .en_q    (en_q),
        .match_q (match_q),
        .count_q (count_q),
        .hit     (hit),
        .rst_req (wdt_rst_req)
    );

    // Read mux; key registers read as zero
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_MATCH: rd_data = match_q;
            A_CTRL:  rd_data = {{(DATA_W-2){1'b0}}, en_q};
            A_STAT:  rd_data = {{(DATA_W-1){1'b0}}, wdt_status};
            A_COUNT: rd_data = count_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PULSE_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic              wdt_rst_req,
    input logic              wdt_status,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] match_q,
    input logic [1:0]        en_q,
    input ulk_state_e        ulk_state
);

    logic [7:0] run_len;

    // Length of the current high run of the reset request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (hold || !wdt_rst_req) begin
            run_len <= '0;
        end else if (run_len != 8'hFF) begin
            run_len <= run_len + 1'b1;
        end
    end

    // R4: a locked write to the match register changes nothing
    a_r4_locked_match_stable: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (wr_en && wr_addr == A_MATCH && ulk_state != ULK_OPEN) |=> $stable(match_q));

    // R7: status rises only after a cycle with counting enabled and count at match
    a_r7_status_from_match: assert property (@(posedge clk) disable iff (!rst_n || hold)
        $rose(wdt_status) |-> $past(en_q[CTRL_RUN] && count_q == match_q));

    // R8: reset request rises together with the status
    a_r8_pulse_with_status: assert property (@(posedge clk) disable iff (!rst_n || hold)
        $rose(wdt_rst_req) |-> wdt_status);

    // R8: the pulse lasts exactly PULSE_LEN cycles
    a_r8_pulse_length: assert property (@(posedge clk) disable iff (!rst_n || hold)
        ($fell(wdt_rst_req) && !$past(hold)) |-> (run_len == 8'(PULSE_LEN)));

    // R9: no pulse unless reset generation was enabled
    a_r9_pulse_needs_bit1: assert property (@(posedge clk) disable iff (!rst_n || hold)
        $rose(wdt_rst_req) |-> $past(en_q[CTRL_RST]));

    // R10: a disabled watchdog clears its count
    a_r10_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n || hold)
        !en_q[CTRL_RUN] |=> (count_q == '0));

    // R12: hold forces reset values
    a_r12_hold_resets: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (count_q == '0 && !wdt_status && !wdt_rst_req && ulk_state == ULK_LOCKED));

endmodule

bind wdt_keyed_top wdt_keyed_chk #(
    .DATA_W    (DATA_W),
    .PULSE_LEN (PULSE_LEN)
) u_chk (.*);

// File: tb/tb_wdt_keyed_top.sv
module tb_wdt_keyed_top;
    import wdt_pkg::*;

    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_match;
        logic [3:0]  req;
    } vec_t;

    // Write sequence and match readback expected after each write
    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 32'h5,    ONES,  4'd4},  // R4 locked write
        '{3'd0, 32'h1234, ONES,  4'd2},  // R2 wrong opening key
        '{3'd1, 32'hEB10, ONES,  4'd2},
        '{3'd2, 32'h5,    ONES,  4'd2},
        '{3'd1, 32'hEB10, ONES,  4'd2},  // R2 reversed order
        '{3'd0, 32'hBABA, ONES,  4'd2},
        '{3'd2, 32'h5,    ONES,  4'd2},
        '{3'd0, 32'hBABA, ONES,  4'd2},  // R2 intervening write
        '{3'd4, 32'h0,    ONES,  4'd2},
        '{3'd1, 32'hEB10, ONES,  4'd2},
        '{3'd2, 32'h5,    ONES,  4'd2},
        '{3'd0, 32'hBABA, ONES,  4'd2},  // R2 opening key twice
        '{3'd0, 32'hBABA, ONES,  4'd2},
        '{3'd1, 32'hEB10, ONES,  4'd2},
        '{3'd2, 32'h7,    ONES,  4'd2},
        '{3'd0, 32'hBABA, ONES,  4'd1},  // R1 correct pair
        '{3'd1, 32'hEB10, ONES,  4'd1},
        '{3'd2, 32'hF,    32'hF, 4'd1},
        '{3'd2, 32'h9,    32'hF, 4'd3},  // R3 second write ignored
        '{3'd0, 32'hBABA, 32'hF, 4'd3},  // R3 pair consumed by a key write
        '{3'd1, 32'hEB10, 32'hF, 4'd3},
        '{3'd0, 32'hBABA, 32'hF, 4'd3},
        '{3'd2, 32'h3,    32'hF, 4'd3}
    };

    logic        clk;
    logic        rst_n;
    logic        hold;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        wdt_rst_req;
    logic        wdt_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    bit mon_on = 0;
    bit rst_seen = 0;

    wdt_keyed_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (hold),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .wdt_rst_req (wdt_rst_req),
        .wdt_status  (wdt_status)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (mon_on && wdt_rst_req) rst_seen = 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] addr, input logic [31:0] exp);
        rd_addr = addr;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // One write, committed on the next rising edge
    task automatic bus_write(input logic [2:0] addr, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_addr = addr;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic unlock();
        bus_write(A_KEY1, 32'hBABA);
        bus_write(A_KEY2, 32'hEB10);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        hold    = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R5: reset values
        chk("R5 reset_req", {31'b0, wdt_rst_req}, 32'h0);
        chk("R5 status", {31'b0, wdt_status}, 32'h0);
        rd_chk("R5 match", A_MATCH, ONES);
        rd_chk("R5 ctrl", A_CTRL, 32'h0);
        rd_chk("R5 count", A_COUNT, 32'h0);
        rd_chk("R4 key reads zero", A_KEY1, 32'h0);
        tick();

        // R1 R2 R3 R4: unlock sequence table
        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].addr, VECS[i].data);
            rd_addr = A_MATCH;
            #1;
            n_cmp++;
            if (rd_data !== VECS[i].exp_match) begin
                n_bad++;
                $display("FAIL R%0d vector %0d: actual %h expected %h",
                         VECS[i].req, i, rd_data, VECS[i].exp_match);
            end
            tick();
        end
        rd_chk("R4 ctrl untouched", A_CTRL, 32'h0);

        // R6 R7 R8: match 15, run with reset generation
        unlock();
        bus_write(A_CTRL, 32'h3);
        rd_chk("R6 count start", A_COUNT, 32'h0);
        repeat (15) tick();
        rd_chk("R6 count at match", A_COUNT, 32'd15);
        chk("R7 status before match", {31'b0, wdt_status}, 32'h0);
        chk("R8 no pulse before match", {31'b0, wdt_rst_req}, 32'h0);
        tick();
        chk("R7 status set", {31'b0, wdt_status}, 32'h1);
        chk("R8 pulse start", {31'b0, wdt_rst_req}, 32'h1);
        rd_chk("R6 count restart", A_COUNT, 32'h0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R8 pulse held", {31'b0, wdt_rst_req}, 32'h1);
        end
        tick();
        chk("R8 pulse ended", {31'b0, wdt_rst_req}, 32'h0);
        rd_chk("R6 count after restart", A_COUNT, 32'd4);

        // R10: disable clears count, keeps status
        unlock();
        bus_write(A_CTRL, 32'h0);
        tick();
        rd_chk("R10 count cleared", A_COUNT, 32'h0);
        repeat (5) tick();
        rd_chk("R10 count stays zero", A_COUNT, 32'h0);
        chk("R10 status kept", {31'b0, wdt_status}, 32'h1);

        // R11: status write semantics
        unlock();
        bus_write(A_STAT, 32'h1);
        chk("R11 write one no effect", {31'b0, wdt_status}, 32'h1);
        unlock();
        bus_write(A_STAT, 32'h0);
        chk("R11 clear", {31'b0, wdt_status}, 32'h0);
        tick();

        // R9 R11: run without reset generation, clear colliding with a match
        unlock();
        rst_seen = 1'b0;
        mon_on   = 1'b1;
        bus_write(A_CTRL, 32'h1);
        repeat (15) tick();
        chk("R7 no status early", {31'b0, wdt_status}, 32'h0);
        tick();
        chk("R9 status set", {31'b0, wdt_status}, 32'h1);
        unlock();
        bus_write(A_STAT, 32'h0);
        chk("R11 clear between matches", {31'b0, wdt_status}, 32'h0);
        repeat (10) tick();
        unlock();
        bus_write(A_STAT, 32'h0);
        chk("R11 set wins over clear", {31'b0, wdt_status}, 32'h1);
        tick();
        mon_on = 1'b0;
        chk("R9 no reset pulse", {31'b0, rst_seen}, 32'h0);

        // R12: hold forces reset values and blocks writes
        hold = 1'b1;
        tick();
        unlock();
        bus_write(A_MATCH, 32'h2);
        rd_chk("R12 match held", A_MATCH, ONES);
        rd_chk("R12 ctrl held", A_CTRL, 32'h0);
        rd_chk("R12 count held", A_COUNT, 32'h0);
        chk("R12 status held", {31'b0, wdt_status}, 32'h0);
        chk("R12 pulse held", {31'b0, wdt_rst_req}, 32'h0);
        hold = 1'b0;
        tick();
        bus_write(A_KEY2, 32'hEB10);
        bus_write(A_MATCH, 32'h2);
        rd_chk("R12 locked after hold", A_MATCH, ONES);
        unlock();
        bus_write(A_MATCH, 32'h2);
        rd_chk("R1 unlock after hold", A_MATCH, 32'h2);

        tick();
        finish_run();
    end

endmodule